// File: doc/BRIEF.md
# Reload Timer with Burst Control

This block is one counter channel of a general-purpose timer. A 32-bit counter counts up one step per clock while the channel is enabled. When it reaches the programmed reload value it returns to zero and emits a one-cycle reload event. The channel runs in one of three modes:

- **Continuous:** it wraps forever.
- **One-shot:** it stops after the first reload.
- **Burst:** it stops after a programmed number of reloads.

A burst can be started in one of two ways. A restart start always begins a fresh burst. A continue start resumes an unfinished burst.

Configuration arrives as plain level inputs. The mode requests and the reload value are taken into the channel only while the enable input is low, so a change made while running waits for the next start. Requesting one-shot and burst together is illegal: the request is refused, an error flag is raised and the previous mode stays in force. A sticky status flag records reload events until software writes a one to clear it, and an interrupt output gates that flag with an enable.

The block carries no data stream, so every pin is a plain control or status level with no handshake.

Top module: `reload_burst_timer`

## Requirements
- R1: In continuous mode (oneshot_req=0, burst_req=0) an enabled counter adds one per clock. At the edge where count equals the active reload value, count becomes 0 and reload_pulse is 1 for exactly the following cycle. A reload value of 0 therefore gives a pulse on every enabled cycle.
- R2: While run_en is low the count and burst count hold their values. A later rising edge of run_en in continuous mode resumes from the held count, and counting starts one cycle after that edge.
- R3: In one-shot mode (oneshot_req=1, burst_req=0) the first reload raises reload_pulse and leaves count at the reload value. Count then holds while run_en stays high. Only a low-then-high sequence on run_en starts it again, from 0.
- R4: In burst mode (oneshot_req=0, burst_req=1) burst_count rises by one on each reload. On the reload that makes burst_count reach or pass burst_target, count holds at the reload value and both counts stop.
- R5: A burst start with start_continue=0 (restart) sets count and burst_count to 0.
- R6: A burst start with start_continue=1 (continue) keeps count and burst_count when burst_count is below burst_target. Otherwise it sets both to 0.
- R7: A high cnt_clr sets count and burst_count to 0 at the next edge. It takes priority over counting and over start handling.
- R8: If oneshot_req and burst_req are both 1 while run_en is low, mode_err becomes 1 and the active mode is unchanged. A legal request sampled with run_en low sets mode_err back to 0.
- R9: The mode requests and reload_in are sampled only while run_en is low. Changes made while run_en is high have no effect until the next start.
- R10: reload_stat becomes 1 the cycle after reload_pulse and stays 1 until a cycle with stat_clr=1 and no reload_pulse. A set wins over a simultaneous clear. irq equals reload_stat AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Count enable; its rising edge is a start |
| cnt_clr | input | 1 | Clears count and burst count |
| reload_in | input | CNT_W | Reload value, sampled while run_en is low |
| burst_target | input | BST_W | Number of reloads in a burst |
| oneshot_req | input | 1 | Requests one-shot mode |
| burst_req | input | 1 | Requests burst mode |
| start_continue | input | 1 | Burst start kind: 0 restart, 1 continue |
| stat_clr | input | 1 | Write-one-to-clear for reload_stat |
| irq_en | input | 1 | Interrupt enable |
| count | output | CNT_W | Current count |
| burst_count | output | BST_W | Reloads completed in the current burst |
| reload_pulse | output | 1 | One-cycle reload event |
| reload_stat | output | 1 | Sticky reload status |
| irq | output | 1 | reload_stat gated by irq_en |
| mode_err | output | 1 | Last sampled mode request was illegal |

## Verification
Continuous runs with small reload values, including a reload value of 0, separate an off-by-one in the wrap point from a wrong pulse cycle. Pausing and resuming with run_en shows whether the count resumes or restarts. One-shot and burst runs, each followed by an enable toggle, separate the stopped state from its release. Partial bursts restarted in continue mode, set against completed bursts restarted the same way, tell the resume branch from the reset branch. Changing reload_in and the mode requests mid-run, and requesting both stopping modes at once, show that configuration is latched only while the channel is idle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RM_CONT    = 2'd0,
    RM_ONESHOT = 2'd1,
    RM_BURST   = 2'd2
  } run_mode_e;
endpackage

// File: rtl/tmr_cfg_latch.sv
module tmr_cfg_latch
  import tmr_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter logic [CNT_W-1:0] RST_RELOAD = 32'hFFFF_FFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             oneshot_req,
  input  logic             burst_req,
  input  logic [CNT_W-1:0] reload_in,
  output run_mode_e        mode_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             mode_err
);

  logic both_req;
  assign both_req = oneshot_req && burst_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= RM_CONT;
      reload_q <= RST_RELOAD;
      mode_err <= 1'b0;
    end else if (!run_en) begin
      reload_q <= reload_in;
      if (both_req) begin
        mode_err <= 1'b1;
      end else begin
        mode_err <= 1'b0;
        mode_q   <= oneshot_req ? RM_ONESHOT : (burst_req ? RM_BURST : RM_CONT);
      end
    end
  end

  // R8
  illegal_mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && both_req) |=> (mode_err && mode_q == $past(mode_q)));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(reload_q) && $stable(mode_q)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int BST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cnt_clr,
  input  logic             start_continue,
  input  run_mode_e        mode,
  input  logic [CNT_W-1:0] reload,
  input  logic [BST_W-1:0] burst_target,
  output logic [CNT_W-1:0] count,
  output logic [BST_W-1:0] burst_count,
  output logic             reload_evt
);

  logic             run_q;
  logic             halted;
  logic             start;
  logic             at_reload;
  logic [BST_W-1:0] bst_next;

  assign start     = run_en && !run_q;
  assign at_reload = (count == reload);
  assign bst_next  = burst_count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      halted      <= 1'b0;
      count       <= '0;
      burst_count <= '0;
      reload_evt  <= 1'b0;
    end else begin
      run_q      <= run_en;
      reload_evt <= 1'b0;
      if (cnt_clr) begin
        count       <= '0;
        burst_count <= '0;
      end else if (start) begin
        halted <= 1'b0;
        case (mode)
          RM_ONESHOT: count <= '0;
          RM_BURST: begin
            if (!start_continue || burst_count >= burst_target) begin
              count       <= '0;
              burst_count <= '0;
            end
          end
          default: ;
        endcase
      end else if (run_en && !halted) begin
        if (at_reload) begin
          reload_evt <= 1'b1;
          case (mode)
            RM_ONESHOT: halted <= 1'b1;
            RM_BURST: begin
              burst_count <= bst_next;
              if (bst_next >= burst_target) halted <= 1'b1;
              else count <= '0;
            end
            default: count <= '0;
          endcase
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  // R7
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0 && burst_count == '0));

  // R3
  halted_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && run_en && run_q && !cnt_clr) |=> $stable(count));

  // R1
  evt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |-> (count == '0 || halted));

endmodule

// File: rtl/tmr_status.sv
module tmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_w1c,
  input  logic irq_en,
  output logic stat,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)       stat <= 1'b0;
    else if (set_evt) stat <= 1'b1;
    else if (clr_w1c) stat <= 1'b0;
  end

  assign irq = stat && irq_en;

  // R10
  stat_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> stat);

  // R10
  stat_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c && !set_evt) |=> !stat);

endmodule

// File: rtl/reload_burst_timer.sv
module reload_burst_timer
  import tmr_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter int               BST_W      = 8,
  parameter logic [CNT_W-1:0] RST_RELOAD = 32'hFFFF_FFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cnt_clr,
  input  logic [CNT_W-1:0] reload_in,
  input  logic [BST_W-1:0] burst_target,
  input  logic             oneshot_req,
  input  logic             burst_req,
  input  logic             start_continue,
  input  logic             stat_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic [BST_W-1:0] burst_count,
  output logic             reload_pulse,
  output logic             reload_stat,
  output logic             irq,
  output logic             mode_err
);

  run_mode_e        mode_q;
  logic [CNT_W-1:0] reload_q;

  tmr_cfg_latch #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .oneshot_req(oneshot_req), .burst_req(burst_req), .reload_in(reload_in),
    .mode_q(mode_q), .reload_q(reload_q), .mode_err(mode_err)
  );

  tmr_core #(.CNT_W(CNT_W), .BST_W(BST_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_clr(cnt_clr),
    .start_continue(start_continue), .mode(mode_q), .reload(reload_q),
    .burst_target(burst_target), .count(count), .burst_count(burst_count),
    .reload_evt(reload_pulse)
  );

  tmr_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_evt(reload_pulse), .clr_w1c(stat_clr),
    .irq_en(irq_en), .stat(reload_stat), .irq(irq)
  );

endmodule

// File: tb/test_reload_burst_timer.sv
module test_reload_burst_timer;
  localparam int CLK_P = 10;
  localparam int CW = 32;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, cnt_clr = 1'b0, oneshot_req = 1'b0, burst_req = 1'b0;
  logic start_continue = 1'b0, stat_clr = 1'b0, irq_en = 1'b0;
  logic [CW-1:0] reload_in = 32'd3;
  logic [BW-1:0] burst_target = 8'd3;
  logic [CW-1:0] count;
  logic [BW-1:0] burst_count;
  logic reload_pulse, reload_stat, irq, mode_err;

  always #(CLK_P/2) clk = ~clk;

  reload_burst_timer i_reload_burst_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_clr(cnt_clr),
    .reload_in(reload_in), .burst_target(burst_target),
    .oneshot_req(oneshot_req), .burst_req(burst_req),
    .start_continue(start_continue), .stat_clr(stat_clr), .irq_en(irq_en),
    .count(count), .burst_count(burst_count), .reload_pulse(reload_pulse),
    .reload_stat(reload_stat), .irq(irq), .mode_err(mode_err)
  );

  // Behavioural reference state. Mode encoding: 0 continuous, 1 one-shot, 2 burst.
  int unsigned   checks = 0, errors = 0;
  bit            done = 1'b0;
  string         cur = "reset";
  logic [CW-1:0] m_cnt, m_rel;
  logic [BW-1:0] m_bcnt, m_bn;
  int            m_mode;
  bit            m_halt, m_runq, m_pulse, m_stat, m_err, m_start, m_evt;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_cnt = '0; m_bcnt = '0; m_halt = 0; m_runq = 0; m_pulse = 0;
      m_stat = 0; m_err = 0; m_mode = 0; m_rel = 32'hFFFF_FFFE;
      return;
    end
    m_stat  = m_pulse ? 1'b1 : (stat_clr ? 1'b0 : m_stat);
    m_start = run_en && !m_runq;
    m_evt   = 0;
    if (cnt_clr) begin
      m_cnt = '0; m_bcnt = '0;
    end else if (m_start) begin
      m_halt = 0;
      if (m_mode == 1) m_cnt = '0;
      else if (m_mode == 2 && (!start_continue || m_bcnt >= burst_target)) begin
        m_cnt = '0; m_bcnt = '0;
      end
    end else if (run_en && !m_halt) begin
      if (m_cnt == m_rel) begin
        m_evt = 1;
        if (m_mode == 0) m_cnt = '0;
        else if (m_mode == 1) m_halt = 1;
        else begin
          m_bn = m_bcnt + 1'b1;
          m_bcnt = m_bn;
          if (m_bn >= burst_target) m_halt = 1; else m_cnt = '0;
        end
      end else m_cnt = m_cnt + 1;
    end
    m_pulse = m_evt;
    m_runq  = run_en;
    if (!run_en) begin
      m_rel = reload_in;
      if (oneshot_req && burst_req) m_err = 1;
      else begin
        m_err = 0;
        m_mode = oneshot_req ? 1 : (burst_req ? 2 : 0);
      end
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      #1;
      chk("count", count, m_cnt);
      chk("burst_count", {24'd0, burst_count}, {24'd0, m_bcnt});
      chk("reload_pulse", {31'd0, reload_pulse}, {31'd0, m_pulse});
      chk("reload_stat", {31'd0, reload_stat}, {31'd0, m_stat});
      chk("irq", {31'd0, irq}, {31'd0, m_stat & irq_en});
      chk("mode_err", {31'd0, mode_err}, {31'd0, m_err});
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur = "reset"; cyc(3);
    rst_n = 1'b1;
    // R1 continuous wrap at reload 3
    cur = "R1"; reload_in = 32'd3; cyc(2);
    run_en = 1'b1; cyc(14);
    // R2 pause then resume
    cur = "R2"; run_en = 1'b0; cyc(3);
    run_en = 1'b1; cyc(6);
    // R10 sticky status, w1c, irq gating, set beats clear
    cur = "R10"; irq_en = 1'b1; cyc(2);
    stat_clr = 1'b1; cyc(6);
    stat_clr = 1'b0; irq_en = 1'b0; cyc(3);
    irq_en = 1'b1; cyc(2);
    // R9 changes while running are ignored
    cur = "R9"; reload_in = 32'd1; oneshot_req = 1'b1; cyc(10);
    // R3 one-shot at reload 4
    cur = "R3"; run_en = 1'b0; reload_in = 32'd4; cyc(2);
    run_en = 1'b1; cyc(10);
    run_en = 1'b0; cyc(1);
    run_en = 1'b1; cyc(8);
    // R4 and R5 burst restart, reload 2, target 3
    cur = "R4"; run_en = 1'b0; oneshot_req = 1'b0; burst_req = 1'b1;
    reload_in = 32'd2; burst_target = 8'd3; start_continue = 1'b0; cyc(2);
    run_en = 1'b1; cyc(14);
    cur = "R5"; run_en = 1'b0; cyc(1);
    run_en = 1'b1; cyc(5);
    // R6 continue: partial burst resumes, completed burst resets
    cur = "R6"; run_en = 1'b0; start_continue = 1'b1; cyc(1);
    run_en = 1'b1; cyc(3);
    run_en = 1'b0; cyc(2);
    run_en = 1'b1; cyc(14);
    run_en = 1'b0; cyc(1);
    run_en = 1'b1; cyc(4);
    // R7 clear mid-burst and during a start
    cur = "R7"; cnt_clr = 1'b1; cyc(1);
    cnt_clr = 1'b0; cyc(4);
    run_en = 1'b0; cyc(1);
    run_en = 1'b1; cnt_clr = 1'b1; cyc(1);
    cnt_clr = 1'b0; cyc(6);
    // R8 illegal request keeps burst mode
    cur = "R8"; run_en = 1'b0; oneshot_req = 1'b1; start_continue = 1'b0; cyc(2);
    run_en = 1'b1; cyc(12);
    run_en = 1'b0; oneshot_req = 1'b0; burst_req = 1'b0; cyc(2);
    // R1 reload value zero
    cur = "R1"; reload_in = 32'd0; cyc(1);
    run_en = 1'b1; cyc(5);
    run_en = 1'b0; cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule